// File: doc/BRIEF.md
# Vector-Context Register Tag Tracker

This block records how each integer register is classed while one prefixed instruction block runs. Each register is either still unclassed, bound to vector, or bound to scalar. A pulse at block start carries the decoded prefix. The prefix holds a vector flag for each of the two source operands, an optional destination flag, and a mask of registers that must stay scalar. The first instruction of the block binds those flags to its own register indices. After that, status spreads through the block's later instructions. A destination that is still unclassed becomes vector if any of its sources is vector. A source that is first met unclassed is frozen as scalar.

For every decoded instruction, the decoder presents the rs1, rs2 and rd indices with a valid strobe. In that same cycle the block returns one vector or scalar bit for each operand. Any new bindings made by that instruction are written into the table at the next clock edge. A block-end pulse clears every binding. A block-start pulse while a block is already open replaces the old block with the new one.

Top module: `vctx_tag_tracker`

## Requirements
- R1: While no block is open, all three result bits are 0, which means scalar. Instructions presented while no block is open bind nothing.
- R2: The first instruction of a block resolves an unclassed rs1 to the rs1 prefix flag and an unclassed rs2 to the rs2 prefix flag. A result bit of 1 means vector.
- R3: On the first instruction of a block, an unclassed rd takes the prefix destination flag when the prefix says that flag is given. Otherwise it takes the OR of the two source prefix flags.
- R4: A binding made by any instruction holds for every later use of that register, in any operand slot, until the block closes.
- R5: On later instructions, an unclassed rd becomes vector exactly when at least one of its resolved sources is vector.
- R6: On later instructions, an unclassed source resolves to scalar. It stays scalar for the rest of the block, even when it later meets vector operands.
- R7: Register 0 always resolves to scalar in every slot and is never bound.
- R8: A block-end pulse discards all bindings and closes the block from the next cycle on.
- R9: Registers set in the scalar mask at block start are bound to scalar at once. The prefix flags and the OR rule cannot make them vector during that block.
- R10: When rs1 equals rs2, both slots get rs1's resolution. An unclassed rd that equals a source takes that source's resolution.
- R11: A block-start pulse during an open block discards the old bindings and loads the new prefix flags and mask. The next instruction counts as a first instruction.
- R12: Results are combinational in the cycle the instruction is valid, and bindings become visible from the next cycle. An instruction in the same cycle as a block-start pulse is ignored: its results are 0 and it binds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronous to clk |
| blk_start | input | 1 | Opens a block and loads the prefix fields below |
| blk_end | input | 1 | Closes the block and clears all bindings |
| pfx_src1_vec | input | 1 | Prefix vector flag for the first instruction's rs1 |
| pfx_src2_vec | input | 1 | Prefix vector flag for the first instruction's rs2 |
| pfx_dst_given | input | 1 | Prefix carries an explicit destination flag |
| pfx_dst_vec | input | 1 | Explicit destination flag, used when pfx_dst_given is 1 |
| pfx_scalar_mask | input | NREG | One bit per register; 1 forces scalar for the block |
| ins_valid | input | 1 | A decoded instruction is present |
| ins_rs1 | input | IDXW | First source register index |
| ins_rs2 | input | IDXW | Second source register index |
| ins_rd | input | IDXW | Destination register index |
| res_rs1_vec | output | 1 | Resolved status of rs1, 1 = vector |
| res_rs2_vec | output | 1 | Resolved status of rs2, 1 = vector |
| res_rd_vec | output | 1 | Resolved status of rd, 1 = vector |

## Verification
A corrupted table entry shows up the next time that register is used in any slot, and the wrong bit appears in that same cycle. A bad first-instruction flag shows up on that very instruction. A lost or late write shows up when the register is used again, because a source that should be frozen scalar would come back carrying a prefix flag, or a vector binding would vanish. A faulty clear shows up on the first instruction after the next block opens, or as a nonzero result while no block is open.

// File: rtl/vctx_pkg.sv
package vctx_pkg;

  // Per-register binding code kept in the table
  typedef logic [1:0] tag_t;
  localparam tag_t TAG_NONE = 2'b00;
  localparam tag_t TAG_VEC  = 2'b01;
  localparam tag_t TAG_SCL  = 2'b10;

  // Operand slots sharing table read and write ports
  localparam int NPORT = 3;
  localparam int P_RS1 = 0;
  localparam int P_RS2 = 1;
  localparam int P_RD  = 2;

  // Prefix fields latched at block start
  typedef struct packed {
    logic vs1;
    logic vs2;
    logic dgiven;
    logic dvec;
  } pfx_t;

endpackage

// File: rtl/vctx_blk_ctrl.sv
// Block lifetime control: open/closed state, first-instruction flag and
// the latched prefix. Start has priority over end.
module vctx_blk_ctrl
  import vctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic blk_start,
  input  logic blk_end,
  input  logic ins_valid,
  input  pfx_t pfx_in,
  output logic active_q,
  output logic first_q,
  output pfx_t pfx_q,
  output logic ins_go,
  output logic tbl_clr,
  output logic mask_load
);

  logic active_d;
  logic first_d;
  logic ctl_en;

  always_comb begin
    ins_go    = ins_valid && active_q && !blk_start;
    tbl_clr   = blk_start || blk_end;
    mask_load = blk_start;
    ctl_en    = blk_start || blk_end || ins_go;

    active_d = active_q;
    first_d  = first_q;
    if (blk_start) begin
      active_d = 1'b1;
      first_d  = 1'b1;
    end else begin
      if (blk_end) begin
        active_d = 1'b0;
      end
      if (ins_go) begin
        first_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
    end else if (ctl_en) begin
      active_q <= active_d;
      first_q  <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q <= '0;
    end else if (blk_start) begin
      pfx_q <= pfx_in;
    end
  end

endmodule

// File: rtl/vctx_tag_table.sv
// One 2-bit binding per register in enabled flops, three read and three
// write ports, single-cycle clear with optional scalar-mask preload.
module vctx_tag_table
  import vctx_pkg::*;
#(
  parameter int NREG = 32,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       mask_load,
  input  logic [NREG-1:0]            scl_mask,
  input  logic [NPORT-1:0]           wr_en,
  input  logic [NPORT-1:0][IDXW-1:0] wr_idx,
  input  tag_t [NPORT-1:0]           wr_tag,
  input  logic [NPORT-1:0][IDXW-1:0] rd_idx,
  output tag_t [NPORT-1:0]           rd_tag
);

  tag_t [NREG-1:0] tbl_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    tag_t ent_q;
    tag_t ent_d;
    logic ent_en;

    always_comb begin
      ent_d  = ent_q;
      ent_en = 1'b0;
      if (clr) begin
        ent_en = 1'b1;
        ent_d  = (mask_load && scl_mask[g] && (g != 0)) ? TAG_SCL : TAG_NONE;
      end else begin
        for (int p = 0; p < NPORT; p++) begin
          if (wr_en[p] && (wr_idx[p] == IDXW'(g))) begin
            ent_en = 1'b1;
            ent_d  = wr_tag[p];
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= TAG_NONE;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign tbl_vec[g] = ent_q;
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rd_tag[p] = tbl_vec[rd_idx[p]];
    end
  end

endmodule

// File: rtl/vctx_resolver.sv
// Combinational operand resolution from pre-instruction table state,
// plus the bindings the instruction leaves behind.
module vctx_resolver
  import vctx_pkg::*;
#(
  parameter int IDXW = 5
) (
  input  logic             go,
  input  logic             first,
  input  pfx_t             pfx,
  input  logic [IDXW-1:0]  rs1,
  input  logic [IDXW-1:0]  rs2,
  input  logic [IDXW-1:0]  rd,
  input  tag_t             t1,
  input  tag_t             t2,
  input  tag_t             td,
  output logic             v1,
  output logic             v2,
  output logic             vd,
  output logic [NPORT-1:0] wr_en,
  output tag_t [NPORT-1:0] wr_tag
);

  tag_t s1;
  tag_t s2;
  tag_t sd;
  logic z1;
  logic z2;
  logic zd;
  logic dflag;

  function automatic tag_t src_bind(tag_t cur, logic zero, logic fst, logic flag);
    if (zero)                 return TAG_SCL;
    else if (cur != TAG_NONE) return cur;
    else if (fst)             return flag ? TAG_VEC : TAG_SCL;
    else                      return TAG_SCL;
  endfunction

  always_comb begin
    z1 = (rs1 == '0);
    z2 = (rs2 == '0);
    zd = (rd == '0);
    dflag = pfx.dgiven ? pfx.dvec : (pfx.vs1 | pfx.vs2);

    s1 = src_bind(t1, z1, first, pfx.vs1);
    s2 = (rs2 == rs1) ? s1 : src_bind(t2, z2, first, pfx.vs2);

    if (zd)                   sd = TAG_SCL;
    else if (td != TAG_NONE)  sd = td;
    else if (rd == rs1)       sd = s1;
    else if (rd == rs2)       sd = s2;
    else if (first)           sd = dflag ? TAG_VEC : TAG_SCL;
    else                      sd = ((s1 == TAG_VEC) || (s2 == TAG_VEC)) ? TAG_VEC : TAG_SCL;

    v1 = go && (s1 == TAG_VEC);
    v2 = go && (s2 == TAG_VEC);
    vd = go && (sd == TAG_VEC);

    wr_en[P_RS1]  = go && !z1 && (t1 == TAG_NONE);
    wr_en[P_RS2]  = go && !z2 && (t2 == TAG_NONE);
    wr_en[P_RD]   = go && !zd && (td == TAG_NONE);
    wr_tag[P_RS1] = s1;
    wr_tag[P_RS2] = s2;
    wr_tag[P_RD]  = sd;
  end

endmodule

// File: rtl/vctx_tag_tracker.sv
// Top: wires block control, binding table and resolver together.
// rst_n is expected to be already synchronized on release upstream.
module vctx_tag_tracker
  import vctx_pkg::*;
#(
  parameter  int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_start,
  input  logic            blk_end,
  input  logic            pfx_src1_vec,
  input  logic            pfx_src2_vec,
  input  logic            pfx_dst_given,
  input  logic            pfx_dst_vec,
  input  logic [NREG-1:0] pfx_scalar_mask,
  input  logic            ins_valid,
  input  logic [IDXW-1:0] ins_rs1,
  input  logic [IDXW-1:0] ins_rs2,
  input  logic [IDXW-1:0] ins_rd,
  output logic            res_rs1_vec,
  output logic            res_rs2_vec,
  output logic            res_rd_vec
);

  pfx_t pfx_in;
  pfx_t pfx_q;
  logic blk_active;
  logic first_q;
  logic ins_go;
  logic tbl_clr;
  logic mask_load;

  logic [NPORT-1:0][IDXW-1:0] op_idx;
  tag_t [NPORT-1:0]           op_tag;
  logic [NPORT-1:0]           wr_en;
  tag_t [NPORT-1:0]           wr_tag;

  always_comb begin
    pfx_in.vs1    = pfx_src1_vec;
    pfx_in.vs2    = pfx_src2_vec;
    pfx_in.dgiven = pfx_dst_given;
    pfx_in.dvec   = pfx_dst_vec;
    op_idx[P_RS1] = ins_rs1;
    op_idx[P_RS2] = ins_rs2;
    op_idx[P_RD]  = ins_rd;
  end

  vctx_blk_ctrl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_start (blk_start),
    .blk_end   (blk_end),
    .ins_valid (ins_valid),
    .pfx_in    (pfx_in),
    .active_q  (blk_active),
    .first_q   (first_q),
    .pfx_q     (pfx_q),
    .ins_go    (ins_go),
    .tbl_clr   (tbl_clr),
    .mask_load (mask_load)
  );

  vctx_tag_table #(
    .NREG (NREG),
    .IDXW (IDXW)
  ) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (tbl_clr),
    .mask_load (mask_load),
    .scl_mask  (pfx_scalar_mask),
    .wr_en     (wr_en),
    .wr_idx    (op_idx),
    .wr_tag    (wr_tag),
    .rd_idx    (op_idx),
    .rd_tag    (op_tag)
  );

  vctx_resolver #(
    .IDXW (IDXW)
  ) u_res (
    .go     (ins_go),
    .first  (first_q),
    .pfx    (pfx_q),
    .rs1    (ins_rs1),
    .rs2    (ins_rs2),
    .rd     (ins_rd),
    .t1     (op_tag[P_RS1]),
    .t2     (op_tag[P_RS2]),
    .td     (op_tag[P_RD]),
    .v1     (res_rs1_vec),
    .v2     (res_rs2_vec),
    .vd     (res_rd_vec),
    .wr_en  (wr_en),
    .wr_tag (wr_tag)
  );

endmodule

// File: rtl/vctx_tag_tracker_chk.sv
module vctx_tag_tracker_chk #(
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            blk_start,
  input logic            blk_end,
  input logic            active,
  input logic            ins_valid,
  input logic [IDXW-1:0] ins_rs1,
  input logic [IDXW-1:0] ins_rs2,
  input logic [IDXW-1:0] ins_rd,
  input logic            res_rs1_vec,
  input logic            res_rs2_vec,
  input logic            res_rd_vec
);

  logic took;
  assign took = ins_valid && active && !blk_start && !blk_end;

  AST_IDLE_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(res_rs1_vec || res_rs2_vec || res_rd_vec)); // R1

  AST_START_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> !(res_rs1_vec || res_rs2_vec || res_rd_vec)); // R12

  AST_ZERO_SRC1_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_rs1 == '0) |-> !res_rs1_vec); // R7

  AST_ZERO_DST_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_rd == '0) |-> !res_rd_vec); // R7

  AST_SAME_SRC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && (ins_rs1 == ins_rs2)) |-> (res_rs1_vec == res_rs2_vec)); // R10

  AST_VEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (took && res_rs1_vec) |=>
      ((ins_valid && !blk_start && (ins_rs1 == $past(ins_rs1))) ? res_rs1_vec : 1'b1)); // R4

  AST_DST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (took && res_rd_vec) |=>
      ((ins_valid && !blk_start && (ins_rs1 == $past(ins_rd))) ? res_rs1_vec : 1'b1)); // R4

  AST_SCL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !res_rs1_vec) |=>
      ((ins_valid && !blk_start && (ins_rs1 == $past(ins_rs1))) ? !res_rs1_vec : 1'b1)); // R6

  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !blk_start) |=> !active); // R8

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> active); // R11

endmodule

bind vctx_tag_tracker vctx_tag_tracker_chk #(.IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .blk_start   (blk_start),
  .blk_end     (blk_end),
  .active      (blk_active),
  .ins_valid   (ins_valid),
  .ins_rs1     (ins_rs1),
  .ins_rs2     (ins_rs2),
  .ins_rd      (ins_rd),
  .res_rs1_vec (res_rs1_vec),
  .res_rs2_vec (res_rs2_vec),
  .res_rd_vec  (res_rd_vec)
);

// File: tb/tb_vctx_tag_tracker.sv
module tb_vctx_tag_tracker;

  localparam int NREG = 32;
  localparam int IDXW = 5;

  logic            clk;
  logic            rst_n;
  logic            blk_start;
  logic            blk_end;
  logic            pfx_src1_vec;
  logic            pfx_src2_vec;
  logic            pfx_dst_given;
  logic            pfx_dst_vec;
  logic [NREG-1:0] pfx_scalar_mask;
  logic            ins_valid;
  logic [IDXW-1:0] ins_rs1;
  logic [IDXW-1:0] ins_rs2;
  logic [IDXW-1:0] ins_rd;
  logic            res_rs1_vec;
  logic            res_rs2_vec;
  logic            res_rd_vec;

  int n_chk;
  int n_bad;
  bit done;

  // Reference state: 0 unclassed, 1 vector, 2 scalar
  int m_tag [NREG];
  bit m_act;
  bit m_first;
  bit m_v1, m_v2, m_dg, m_dv;

  vctx_tag_tracker #(.NREG(NREG)) dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .blk_start       (blk_start),
    .blk_end         (blk_end),
    .pfx_src1_vec    (pfx_src1_vec),
    .pfx_src2_vec    (pfx_src2_vec),
    .pfx_dst_given   (pfx_dst_given),
    .pfx_dst_vec     (pfx_dst_vec),
    .pfx_scalar_mask (pfx_scalar_mask),
    .ins_valid       (ins_valid),
    .ins_rs1         (ins_rs1),
    .ins_rs2         (ins_rs2),
    .ins_rd          (ins_rd),
    .res_rs1_vec     (res_rs1_vec),
    .res_rs2_vec     (res_rs2_vec),
    .res_rd_vec      (res_rd_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input bit got, input bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  function automatic int src_res(int r, bit flag);
    if (r == 0) return 2;
    if (m_tag[r] != 0) return m_tag[r];
    if (m_first) return flag ? 1 : 2;
    return 2;
  endfunction

  task automatic model_clear(input bit [NREG-1:0] msk, input bit load);
    for (int i = 0; i < NREG; i++) m_tag[i] = (load && msk[i] && i != 0) ? 2 : 0;
  endtask

  // One cycle: drive at negedge, check mid-cycle, then advance the model
  task automatic step(input bit st, input bit en, input bit [NREG-1:0] msk,
                      input bit a1, input bit a2, input bit dg, input bit dv,
                      input bit vld, input int r1, input int r2, input int rd,
                      input string req);
    bit go;
    int s1, s2, sd;
    @(negedge clk);
    blk_start = st; blk_end = en; pfx_scalar_mask = msk;
    pfx_src1_vec = a1; pfx_src2_vec = a2; pfx_dst_given = dg; pfx_dst_vec = dv;
    ins_valid = vld; ins_rs1 = IDXW'(r1); ins_rs2 = IDXW'(r2); ins_rd = IDXW'(rd);
    #1;
    go = vld && m_act && !st;
    s1 = src_res(r1, m_v1);
    s2 = (r2 == r1) ? s1 : src_res(r2, m_v2);
    if (rd == 0) sd = 2;
    else if (m_tag[rd] != 0) sd = m_tag[rd];
    else if (rd == r1) sd = s1;
    else if (rd == r2) sd = s2;
    else if (m_first) sd = (dg_sel(m_dg, m_dv, m_v1, m_v2)) ? 1 : 2;
    else sd = (s1 == 1 || s2 == 1) ? 1 : 2;
    chk(req, "rs1", res_rs1_vec, go && s1 == 1);
    chk(req, "rs2", res_rs2_vec, go && s2 == 1);
    chk(req, "rd",  res_rd_vec,  go && sd == 1);
    if (st) begin
      model_clear(msk, 1'b1);
      m_act = 1; m_first = 1;
      m_v1 = a1; m_v2 = a2; m_dg = dg; m_dv = dv;
    end else if (en) begin
      model_clear(msk, 1'b0);
      m_act = 0;
    end else if (go) begin
      if (r1 != 0 && m_tag[r1] == 0) m_tag[r1] = s1;
      if (r2 != 0 && m_tag[r2] == 0) m_tag[r2] = s2;
      if (rd != 0 && m_tag[rd] == 0) m_tag[rd] = sd;
      m_first = 0;
    end
  endtask

  function automatic bit dg_sel(bit dg, bit dv, bit a1, bit a2);
    return dg ? dv : (a1 | a2);
  endfunction

  task automatic open_blk(input bit [NREG-1:0] msk, input bit a1, input bit a2,
                          input bit dg, input bit dv, input string req);
    step(1, 0, msk, a1, a2, dg, dv, 0, 0, 0, 0, req);
  endtask

  task automatic ins(input int r1, input int r2, input int rd, input string req);
    step(0, 0, '0, 0, 0, 0, 0, 1, r1, r2, rd, req);
  endtask

  task automatic close_blk(input string req);
    step(0, 1, '0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    bit st, en, vld;
    bit [NREG-1:0] msk;
    n_chk = 0; n_bad = 0; done = 0;
    m_act = 0; m_first = 0; m_v1 = 0; m_v2 = 0; m_dg = 0; m_dv = 0;
    model_clear('0, 1'b0);
    rst_n = 1'b0;
    blk_start = 0; blk_end = 0; pfx_scalar_mask = '0;
    pfx_src1_vec = 1; pfx_src2_vec = 1; pfx_dst_given = 0; pfx_dst_vec = 0;
    ins_valid = 1; ins_rs1 = 5; ins_rs2 = 6; ins_rd = 7;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "reset rs1", res_rs1_vec, 1'b0);
    chk("R1", "reset rs2", res_rs2_vec, 1'b0);
    chk("R1", "reset rd",  res_rd_vec,  1'b0);
    rst_n = 1'b1;

    // R1: idle instruction results scalar
    ins(5, 6, 7, "R1");

    // R2 R3 R5 R6: vs1=1 vs2=0, no destination flag
    open_blk('0, 1, 0, 0, 0, "R12");
    ins(5, 12, 3, "R2");
    ins(5, 3, 7, "R5");
    ins(4, 4, 9, "R6");
    ins(5, 4, 7, "R6");
    ins(12, 3, 13, "R4");
    close_blk("R8");
    ins(5, 3, 7, "R8");

    // R3: explicit destination flag
    open_blk('0, 0, 0, 1, 1, "R3");
    ins(1, 2, 6, "R3");
    ins(6, 1, 8, "R5");
    ins(2, 8, 10, "R4");

    // R7: register 0
    open_blk('0, 1, 1, 0, 0, "R11");
    ins(0, 3, 0, "R7");
    ins(3, 0, 14, "R7");

    // R9: scalar mask
    open_blk((32'h1 << 5) | (32'h1 << 9) | 32'h1, 1, 1, 0, 0, "R9");
    ins(5, 2, 9, "R9");
    ins(2, 2, 9, "R9");
    ins(2, 5, 11, "R9");

    // R10: aliased operands
    open_blk('0, 1, 0, 0, 0, "R10");
    ins(3, 3, 4, "R10");
    ins(3, 11, 11, "R10");
    ins(11, 3, 15, "R10");

    // R11 R12: restart during an open block, instruction in start cycle ignored
    step(1, 0, '0, 0, 1, 1, 0, 1, 3, 4, 15, "R12");
    ins(3, 4, 15, "R11");
    ins(4, 11, 16, "R11");

    // R1: idle instructions bind nothing
    close_blk("R8");
    ins(3, 4, 5, "R1");
    open_blk('0, 1, 1, 0, 0, "R1");
    ins(3, 4, 5, "R1");

    // Constrained random mix
    void'($urandom(32'h1357_2468));
    for (int c = 0; c < 4000; c++) begin
      st  = ($urandom % 100) < 6;
      en  = !st && (($urandom % 100) < 4);
      vld = ($urandom % 100) < 85;
      msk = ($urandom & $urandom & $urandom);
      step(st, en, msk, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           vld, int'($urandom % 12), int'($urandom % 12), int'($urandom % 12), "R4");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule